// File: doc/BRIEF.md
# Masked Interrupt Latch

This block collects up to eight device interrupt requests into one pending byte and drives a single level interrupt line toward an upstream controller. Device logic sets pending bits with a one-cycle set vector and removes them with a clear vector. Software programs an enable mask and retires requests through a small byte-wide register port. The upstream line is high whenever any pending bit is also enabled. There is no priority, vectoring or in-service tracking.

A second, cascaded bank exists only as a stub. Its mask can be written and read back, its pending register always reads zero, and writes to its acknowledge register are accepted and do nothing. Accesses of the wrong size, or to an offset that has no register for that direction, raise a one-cycle error flag and leave every piece of state as it was.

Top module: `masked_irq_latch`

## Requirements
- R1: After reset the pending byte is 0x00, the enable mask is 0x00 (all sources masked, so a mask read returns 0xFF), irqOut is low, and regErr and regRdata are 0.
- R2: A byte write to offset 1 stores the bitwise complement of the written byte as the enable mask. A byte read of offset 1 returns that complement again, which is the byte that was written.
- R3: irqOut is high exactly when (pending AND enable) is non-zero. It follows any change of pending or enable on the same clock edge that changes them, so a mask write can raise or drop it.
- R4: Each bit set in setVec sets that pending bit, and each bit set in clrVec clears it. When setVec and clrVec name the same bit in one cycle, the bit ends up set.
- R5: A byte write to offset 2 clears the pending bit whose index is regWdata[3:0]. An index from 8 to 15 clears nothing.
- R6: When setVec and an acknowledge write name the same bit in one cycle, the bit ends up set and irqOut stays high if that bit is enabled.
- R7: Reading offset 0 returns the pending byte, zero-extended to 64 bits. The read is accepted with regSize 0 (one byte) or regSize 3 (eight bytes).
- R8: Offset 4 (secondary pending) reads 0x00. Offset 5 (secondary mask) stores a byte and reads it back unchanged, with no effect on irqOut. A write to offset 6 (secondary acknowledge) has no effect on pending.
- R9: Any other access raises regErr for one cycle per access, returns regRdata 0, and changes no state. This covers a regSize other than 0 or 3, regSize 3 anywhere but a read of offset 0, reads of offsets 2 and 6, writes to offsets 0 and 4, and offsets 3 and 7.
- R10: regRdata and regErr are registered. They reflect the access presented in the previous cycle, and regRdata is 0 in a cycle after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setVec | input | 8 | Device requests, one-cycle set of pending bits |
| clrVec | input | 8 | Device withdrawals, one-cycle clear of pending bits |
| regValid | input | 1 | Register access present this cycle |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 3 | Register offset |
| regSize | input | 2 | Access size code: 0 one byte, 3 eight bytes |
| regWdata | input | 8 | Write data |
| regRdata | output | 64 | Read data, one cycle after the access |
| regErr | output | 1 | One-cycle error flag for a rejected access |
| irqOut | output | 1 | Level interrupt toward the upstream controller |

## Verification
Two device strobes and a software acknowledge can land on the same pending bit in one cycle, and so can a set and a clear strobe. The bench drives setVec together with an acknowledge write naming the same index, and setVec together with clrVec on the same bit. It then judges the outcome by reading the pending byte back and by sampling irqOut. In both cases the bit must survive and the line must stay high.

// File: rtl/mil_pkg.sv
package mil_pkg;
  localparam int PEND_W = 8;
  localparam int RD_W   = 64;
  localparam int ADDR_W = 3;
  localparam int SIZE_W = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_PEND, RD_MASK, RD_SECMASK, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrAck;
    logic   wrSecMask;
    rdSel_e rdSel;
    logic   bad;
  } ctl_t;
endpackage

// File: rtl/mil_ctrl.sv
module mil_ctrl
  import mil_pkg::*;
(
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SIZE_W-1:0] regSize,
  output ctl_t              ctl
);
  localparam logic [SIZE_W-1:0] SZ_BYTE = '0;
  localparam logic [SIZE_W-1:0] SZ_WIDE = '1;

  logic isByte, isWide;
  assign isByte = (regSize == SZ_BYTE);
  assign isWide = (regSize == SZ_WIDE);

  always_comb begin
    ctl = '{wrEnable: 1'b0, wrAck: 1'b0, wrSecMask: 1'b0, rdSel: RD_NONE, bad: 1'b0};
    if (regValid) begin
      case (regAddr)
        3'd0: if (!regWrite && (isByte || isWide)) ctl.rdSel = RD_PEND;
              else ctl.bad = 1'b1;
        3'd1: if (!isByte) ctl.bad = 1'b1;
              else if (regWrite) ctl.wrEnable = 1'b1;
              else ctl.rdSel = RD_MASK;
        3'd2: if (isByte && regWrite) ctl.wrAck = 1'b1;
              else ctl.bad = 1'b1;
        3'd4: if (isByte && !regWrite) ctl.rdSel = RD_ZERO;
              else ctl.bad = 1'b1;
        3'd5: if (!isByte) ctl.bad = 1'b1;
              else if (regWrite) ctl.wrSecMask = 1'b1;
              else ctl.rdSel = RD_SECMASK;
        3'd6: if (!(isByte && regWrite)) ctl.bad = 1'b1;
        default: ctl.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mil_datapath.sv
module mil_datapath
  import mil_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [PEND_W-1:0] setVec,
  input  logic [PEND_W-1:0] clrVec,
  input  logic [7:0]        wdata,
  output logic [PEND_W-1:0] pendQ,
  output logic [PEND_W-1:0] enQ,
  output logic [RD_W-1:0]   rdata,
  output logic              err,
  output logic              irqOut
);
  logic [PEND_W-1:0] secMaskQ;
  logic [PEND_W-1:0] ackMask, pendNext, enNext;
  logic [RD_W-1:0]   rdNext;

  always_comb begin
    ackMask = '0;
    if (ctl.wrAck && (int'(wdata[3:0]) < PEND_W)) ackMask[wdata[3:0]] = 1'b1;
  end

  assign pendNext = (pendQ & ~clrVec & ~ackMask) | setVec;
  assign enNext   = ctl.wrEnable ? ~wdata[PEND_W-1:0] : enQ;

  always_comb begin
    rdNext = '0;
    case (ctl.rdSel)
      RD_PEND:    rdNext[PEND_W-1:0] = pendQ;
      RD_MASK:    rdNext[PEND_W-1:0] = ~enQ;
      RD_SECMASK: rdNext[PEND_W-1:0] = secMaskQ;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      enQ      <= '0;
      secMaskQ <= '0;
      rdata    <= '0;
      err      <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      pendQ    <= pendNext;
      enQ      <= enNext;
      if (ctl.wrSecMask) secMaskQ <= wdata[PEND_W-1:0];
      rdata    <= rdNext;
      err      <= ctl.bad;
      irqOut   <= |(pendNext & enNext);
    end
  end
endmodule

// File: rtl/masked_irq_latch.sv
module masked_irq_latch
  import mil_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  setVec,
  input  logic [7:0]  clrVec,
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [2:0]  regAddr,
  input  logic [1:0]  regSize,
  input  logic [7:0]  regWdata,
  output logic [63:0] regRdata,
  output logic        regErr,
  output logic        irqOut
);
  ctl_t              ctl;
  logic [PEND_W-1:0] pendQ, enQ;

  mil_ctrl u_ctrl (
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regSize(regSize), .ctl(ctl)
  );

  mil_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .setVec(setVec), .clrVec(clrVec),
    .wdata(regWdata), .pendQ(pendQ), .enQ(enQ), .rdata(regRdata),
    .err(regErr), .irqOut(irqOut)
  );
endmodule

// File: rtl/mil_checker.sv
module mil_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  setVec,
  input logic [7:0]  clrVec,
  input logic        regValid,
  input logic        regWrite,
  input logic [63:0] regRdata,
  input logic        regErr,
  input logic        irqOut,
  input logic [7:0]  pendQ,
  input logic [7:0]  enQ
);
  assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(pendQ & enQ));

  assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != 8'h00) |=> ((pendQ & $past(setVec)) == $past(setVec)));

  assert_clr_removes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec != 8'h00 && setVec == 8'h00) |=> ((pendQ & $past(clrVec)) == 8'h00));

  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && regWrite) |=> $stable(enQ));

  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> (regRdata == 64'h0));

  assert_err_needs_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regValid |=> !regErr);

  assert_no_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regValid |=> (regRdata == 64'h0));
endmodule

bind masked_irq_latch mil_checker u_chk (
  .clk(clk), .rstN(rstN), .setVec(setVec), .clrVec(clrVec),
  .regValid(regValid), .regWrite(regWrite), .regRdata(regRdata),
  .regErr(regErr), .irqOut(irqOut), .pendQ(pendQ), .enQ(enQ)
);

// File: tb/masked_irq_latch_bench.sv
`timescale 1ns/1ps
module masked_irq_latch_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  setVec = '0, clrVec = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [1:0]  regSize = '0;
  logic [7:0]  regWdata = '0;
  logic [63:0] regRdata;
  logic        regErr, irqOut;

  int checks = 0;
  int errors = 0;
  logic [63:0] rd;
  logic        er;

  always #10 clk = ~clk;

  masked_irq_latch u_masked_irq_latch (
    .clk(clk), .rstN(rstN), .setVec(setVec), .clrVec(clrVec),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regSize(regSize), .regWdata(regWdata), .regRdata(regRdata),
    .regErr(regErr), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic busOp(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                       input logic [7:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regAddr = a; regSize = sz; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    rd = regRdata; er = regErr;
  endtask

  task automatic pulse(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    setVec = s; clrVec = c;
    @(negedge clk);
    setVec = '0; clrVec = '0;
  endtask

  task automatic tReset;
    chk("R1 irq", {63'h0, irqOut}, 64'h0);
    chk("R1 err", {63'h0, regErr}, 64'h0);
    chk("R1 rdata", regRdata, 64'h0);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R1 pending", rd, 64'h0);
    busOp(1'b0, 3'd1, 2'd0, 8'h00); chk("R1 mask", rd, 64'hFF);
    pulse(8'h01, 8'h00);
    chk("R1 masked no irq", {63'h0, irqOut}, 64'h0);
    pulse(8'h00, 8'h01);
  endtask

  task automatic tMask;
    busOp(1'b1, 3'd1, 2'd0, 8'hA5); chk("R2 write ok", {63'h0, er}, 64'h0);
    busOp(1'b0, 3'd1, 2'd0, 8'h00); chk("R2 readback", rd, 64'hA5);
    busOp(1'b1, 3'd1, 2'd0, 8'hFF);
  endtask

  task automatic tIrqFollow;
    pulse(8'h08, 8'h00);
    chk("R3 masked stays low", {63'h0, irqOut}, 64'h0);
    busOp(1'b1, 3'd1, 2'd0, 8'hF7);
    chk("R3 unmask raises", {63'h0, irqOut}, 64'h1);
    busOp(1'b1, 3'd1, 2'd0, 8'hFF);
    chk("R3 mask drops", {63'h0, irqOut}, 64'h0);
    busOp(1'b1, 3'd1, 2'd0, 8'h00);
    chk("R3 unmask all", {63'h0, irqOut}, 64'h1);
    pulse(8'h00, 8'h08);
    chk("R3 clear drops", {63'h0, irqOut}, 64'h0);
  endtask

  task automatic tSetClear;
    pulse(8'h11, 8'h00);
    pulse(8'h40, 8'h01);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R4 set/clear", rd, 64'h50);
    pulse(8'h10, 8'h10);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R4 set beats clear", rd, 64'h50);
    pulse(8'h00, 8'hFF);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R4 clear all", rd, 64'h0);
  endtask

  task automatic tAck;
    pulse(8'h84, 8'h00);
    busOp(1'b1, 3'd2, 2'd0, 8'hF2);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R5 ack index 2", rd, 64'h80);
    busOp(1'b1, 3'd2, 2'd0, 8'h09);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R5 index 9 no-op", rd, 64'h80);
    busOp(1'b1, 3'd2, 2'd0, 8'h07);
    chk("R5 irq drops", {63'h0, irqOut}, 64'h0);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R5 ack index 7", rd, 64'h0);
  endtask

  task automatic tRace;
    @(negedge clk);
    setVec = 8'h02;
    regValid = 1'b1; regWrite = 1'b1; regAddr = 3'd2; regSize = 2'd0; regWdata = 8'h01;
    @(negedge clk);
    setVec = '0; regValid = 1'b0; regWrite = 1'b0;
    chk("R6 irq kept", {63'h0, irqOut}, 64'h1);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R6 bit kept", rd, 64'h02);
  endtask

  task automatic tWide;
    busOp(1'b0, 3'd0, 2'd3, 8'h00);
    chk("R7 wide read", rd, 64'h02);
    chk("R7 wide no err", {63'h0, er}, 64'h0);
  endtask

  task automatic tSecondary;
    busOp(1'b1, 3'd1, 2'd0, 8'hFF);
    busOp(1'b1, 3'd5, 2'd0, 8'h00);
    chk("R8 sec mask no irq", {63'h0, irqOut}, 64'h0);
    busOp(1'b0, 3'd5, 2'd0, 8'h00); chk("R8 sec mask readback", rd, 64'h00);
    busOp(1'b1, 3'd5, 2'd0, 8'h3C);
    busOp(1'b0, 3'd5, 2'd0, 8'h00); chk("R8 sec mask 3C", rd, 64'h3C);
    busOp(1'b0, 3'd4, 2'd0, 8'h00); chk("R8 sec pending zero", rd, 64'h0);
    busOp(1'b1, 3'd6, 2'd0, 8'h01);
    chk("R8 sec ack no err", {63'h0, er}, 64'h0);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R8 sec ack ignored", rd, 64'h02);
  endtask

  task automatic tErrors;
    busOp(1'b1, 3'd1, 2'd1, 8'h00);
    chk("R9 bad size err", {63'h0, er}, 64'h1);
    busOp(1'b0, 3'd1, 2'd0, 8'h00); chk("R9 mask unchanged", rd, 64'hFF);
    busOp(1'b0, 3'd1, 2'd3, 8'h00);
    chk("R9 wide mask err", {63'h0, er}, 64'h1); chk("R9 err data", rd, 64'h0);
    busOp(1'b0, 3'd3, 2'd0, 8'h00); chk("R9 unmapped err", {63'h0, er}, 64'h1);
    busOp(1'b1, 3'd2, 2'd3, 8'h01); chk("R9 wide ack err", {63'h0, er}, 64'h1);
    busOp(1'b0, 3'd0, 2'd0, 8'h00); chk("R9 pending unchanged", rd, 64'h02);
    chk("R9 err one cycle", {63'h0, er}, 64'h0);
    @(negedge clk);
    chk("R10 idle rdata", regRdata, 64'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMask();
    tIrqFollow();
    tSetClear();
    busOp(1'b1, 3'd1, 2'd0, 8'h00);
    tAck();
    tRace();
    tWide();
    tSecondary();
    tErrors();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule